// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block sits beside a UART core and owns its modem handshake lines. A three-bit flow-control code chooses between hand-driven lines and automatic flow control. A separate pin-mode code decides whether automatic flow control runs on the request/clear pair or on the terminal-ready/set-ready pair. In automatic operation the local request line throttles the far end from the receive FIFO fill level, with hysteresis between a stop threshold and a lower resume threshold. The far end's clear line gates the start of each outgoing character.

A fourth flow-control bit enables half-duplex operation. In that mode a transceiver-enable output is driven to its transmit level for as long as the transmitter is busy, plus one guard cycle, so the line driver stays on through the last stop bit. A polarity input picks which level means transmit. All handshake pins are active low. The UART core reports `tx_busy` from the start bit to the end of the last stop bit, and it starts a character only in a cycle where `tx_permit` is high.

The block has four state machines or decoders. The mode decoder has the modes MANUAL, RTS_CTS and DTR_DSR. The receive throttle has the states THR_OPEN and THR_HOLD. It moves OPEN→HOLD when the level is at or above `stop_thresh`, and HOLD→OPEN when the level is below `resume_thresh`. The transmit gate has the states GATE_IDLE and GATE_BUSY. It moves IDLE→BUSY when `tx_busy` is high, and BUSY→IDLE when `tx_busy` is low. The half-duplex driver has the states HDX_RX and HDX_TX. It moves RX→TX on `tx_busy` and TX→RX when `tx_busy` is low.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset the throttle is open, the gate is idle and the half-duplex driver is in HDX_RX. With flow code 000, man bits 0, te_pol 0 and tx_busy 0, this gives rts_n=1, dtr_n=1, tx_permit=1 and xcvr_en=1.
- R2: With `flow_ctl[2:0]`=000 (manual), rts_n equals the inverse of man_rts and dtr_n equals the inverse of man_dtr. In this mode cts_n and dsr_n have no effect on tx_permit.
- R3: In request/clear mode (`flow_ctl[2:0]`=001, `pin_mode`≠010), rts_n goes high in the cycle after a clock edge at which rx_level ≥ stop_thresh. dtr_n follows man_dtr in this mode.
- R4: In automatic mode, once the request line is high it stays high while rx_level ≥ resume_thresh. It goes low in the cycle after an edge at which rx_level < resume_thresh.
- R5: In request/clear mode, tx_permit is low whenever cts_n is high. When the gate is idle and tx_busy is low, tx_permit equals the inverse of cts_n.
- R6: tx_permit is low while tx_busy is high, and for one cycle after tx_busy falls, whatever the clear line does meanwhile. A character in flight is never cut short by the gate.
- R7: With `flow_ctl[2:0]`=001 and `pin_mode`=010, dtr_n carries the throttle and dsr_n gates tx_permit. rts_n follows man_rts and cts_n has no effect.
- R8: With `flow_ctl[3]`=1, xcvr_en is at its transmit level from the cycle tx_busy rises through the cycle after tx_busy falls. At all other times it is at the receive level.
- R9: The transmit level of xcvr_en equals te_pol: 0 drives it low while transmitting, 1 drives it high. The receive level is the inverse of te_pol.
- R10: With `flow_ctl[3]`=0, xcvr_en stays at the receive level (inverse of te_pol), even while tx_busy is high.
- R11: Flow codes other than 000 and 001 act like manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W | Receive FIFO fill level |
| stop_thresh | input | LVL_W | Level at which the far end is throttled |
| resume_thresh | input | LVL_W | Level below which the far end is released |
| flow_ctl | input | 4 | [2:0] flow code, [3] half-duplex enable |
| pin_mode | input | 3 | 010 moves automatic flow control to the DTR/DSR pair |
| te_pol | input | 1 | Transmit level of xcvr_en |
| man_rts | input | 1 | Request line value in manual use (1 = asserted) |
| man_dtr | input | 1 | Terminal-ready value in manual use (1 = asserted) |
| cts_n | input | 1 | Far-end clear, active low |
| dsr_n | input | 1 | Far-end set-ready, active low |
| tx_busy | input | 1 | Transmitter sending a character |
| rts_n | output | 1 | Request line, active low |
| dtr_n | output | 1 | Terminal-ready line, active low |
| tx_permit | output | 1 | Transmitter may start a character |
| xcvr_en | output | 1 | Transceiver enable |

## Verification
The receive level is ramped up through the stop threshold and back down through the resume threshold. This separates a correct hysteresis band from a single-threshold comparator or an off-by-one on either bound. Characters are sent with the clear line steady, dropped mid-character, and held off before a start. This tells a gate that latches per character apart from one that passes the clear line straight through. The same ramps and characters are repeated on the terminal-ready pair, under unused flow codes, and with half-duplex at both polarities and disabled. Together these expose a wrong pin routing, a wrong mode decode or a missing guard cycle on the transceiver enable.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

    localparam logic [2:0] FC_MANUAL = 3'b000;
    localparam logic [2:0] FC_AUTO   = 3'b001;
    localparam logic [2:0] PIN_DTR   = 3'b010;

    typedef enum logic [1:0] {
        MODE_MANUAL,
        MODE_RTS_CTS,
        MODE_DTR_DSR
    } hs_mode_e;

    typedef enum logic {
        THR_OPEN,
        THR_HOLD
    } thr_state_e;

    typedef enum logic {
        GATE_IDLE,
        GATE_BUSY
    } gate_state_e;

    typedef enum logic {
        HDX_RX,
        HDX_TX
    } hdx_state_e;

endpackage

// File: rtl/fc_mode_decode.sv
module fc_mode_decode
    import flowctl_pkg::*;
(
    input  logic [2:0] flow_code,
    input  logic [2:0] pin_code,
    output hs_mode_e   mode
);

    always_comb begin
        if (flow_code != FC_AUTO)
            mode = MODE_MANUAL;
        else if (pin_code == PIN_DTR)
            mode = MODE_DTR_DSR;
        else
            mode = MODE_RTS_CTS;
    end

endmodule

// File: rtl/fc_rx_throttle.sv
module fc_rx_throttle
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] stop_th,
    input  logic [LVL_W-1:0] resume_th,
    output logic             hold
);

    thr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= THR_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_OPEN: if (level >= stop_th)  state_d = THR_HOLD;
            THR_HOLD: if (level < resume_th) state_d = THR_OPEN;
        endcase
    end

    always_comb begin
        hold = (state_q == THR_HOLD);
    end

endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tx_busy,
    output logic permit
);

    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (tx_busy)  state_d = GATE_BUSY;
            GATE_BUSY: if (!tx_busy) state_d = GATE_IDLE;
        endcase
    end

    always_comb begin
        permit = (state_q == GATE_IDLE) && clear && !tx_busy;
    end

endmodule

// File: rtl/fc_hdx_drive.sv
module fc_hdx_drive
    import flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pol,
    input  logic tx_busy,
    output logic xcvr_en
);

    hdx_state_e state_q, state_d;
    logic       tx_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HDX_RX;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HDX_RX: if (tx_busy)  state_d = HDX_TX;
            HDX_TX: if (!tx_busy) state_d = HDX_RX;
        endcase
    end

    always_comb begin
        tx_phase = tx_busy || (state_q == HDX_TX);
        xcvr_en  = (enable && tx_phase) ? pol : !pol;
    end

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] stop_thresh,
    input  logic [LVL_W-1:0] resume_thresh,
    input  logic [3:0]       flow_ctl,
    input  logic [2:0]       pin_mode,
    input  logic             te_pol,
    input  logic             man_rts,
    input  logic             man_dtr,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             tx_busy,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_permit,
    output logic             xcvr_en
);

    localparam int HDX_BIT = 3;

    hs_mode_e mode;
    logic     hold;
    logic     clear;

    fc_mode_decode u_dec (
        .flow_code (flow_ctl[2:0]),
        .pin_code  (pin_mode),
        .mode      (mode)
    );

    fc_rx_throttle #(.LVL_W(LVL_W)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (rx_level),
        .stop_th   (stop_thresh),
        .resume_th (resume_thresh),
        .hold      (hold)
    );

    fc_tx_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .tx_busy (tx_busy),
        .permit  (tx_permit)
    );

    fc_hdx_drive u_hdx (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (flow_ctl[HDX_BIT]),
        .pol     (te_pol),
        .tx_busy (tx_busy),
        .xcvr_en (xcvr_en)
    );

    always_comb begin
        rts_n = !man_rts;
        dtr_n = !man_dtr;
        clear = 1'b1;
        unique case (mode)
            MODE_MANUAL: ;
            MODE_RTS_CTS: begin
                rts_n = hold;
                clear = !cts_n;
            end
            MODE_DTR_DSR: begin
                dtr_n = hold;
                clear = !dsr_n;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
    parameter int LVL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] stop_thresh,
    input logic [LVL_W-1:0] resume_thresh,
    input logic [3:0]       flow_ctl,
    input logic [2:0]       pin_mode,
    input logic             te_pol,
    input logic             man_rts,
    input logic             man_dtr,
    input logic             cts_n,
    input logic             tx_busy,
    input logic             rts_n,
    input logic             dtr_n,
    input logic             tx_permit,
    input logic             xcvr_en
);

    logic auto_rts, manual;
    assign auto_rts = (flow_ctl[2:0] == 3'b001) && (pin_mode != 3'b010);
    assign manual   = (flow_ctl[2:0] != 3'b001);

    // R2
    manual_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        manual |-> (rts_n == !man_rts) && (dtr_n == !man_dtr));

    // R3
    rts_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && rx_level >= stop_thresh) |=> (!auto_rts || rts_n));

    // R4
    rts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && rts_n && rx_level >= resume_thresh) |=> (!auto_rts || rts_n));

    // R5
    permit_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && cts_n) |-> !tx_permit);

    // R6
    permit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> !tx_permit);

    // R8
    hdx_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_ctl[3] && tx_busy) |=> (!flow_ctl[3] || !$stable(te_pol) || xcvr_en == te_pol));

    // R10
    hdx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_ctl[3] |-> (xcvr_en == !te_pol));

endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_level      (rx_level),
    .stop_thresh   (stop_thresh),
    .resume_thresh (resume_thresh),
    .flow_ctl      (flow_ctl),
    .pin_mode      (pin_mode),
    .te_pol        (te_pol),
    .man_rts       (man_rts),
    .man_dtr       (man_dtr),
    .cts_n         (cts_n),
    .tx_busy       (tx_busy),
    .rts_n         (rts_n),
    .dtr_n         (dtr_n),
    .tx_permit     (tx_permit),
    .xcvr_en       (xcvr_en)
);

// File: tb/test_uart_flow_ctl.sv
module test_uart_flow_ctl;

    localparam int LVL_W = 9;

    logic             clk = 0;
    logic             rst_n = 0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] stop_thresh = 9'd12;
    logic [LVL_W-1:0] resume_thresh = 9'd4;
    logic [3:0]       flow_ctl = 4'b0000;
    logic [2:0]       pin_mode = 3'b000;
    logic             te_pol = 0, man_rts = 0, man_dtr = 0;
    logic             cts_n = 1, dsr_n = 1, tx_busy = 0;
    logic             rts_n, dtr_n, tx_permit, xcvr_en;

    int    total = 0, bad = 0, cycles = 0;
    bit    done = 0;
    string pin_req = "R2";
    bit    m_hold = 0, m_busy_d = 0;

    always #2 clk = !clk;

    uart_flow_ctl #(.LVL_W(LVL_W)) i_uart_flow_ctl (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .stop_thresh(stop_thresh),
        .resume_thresh(resume_thresh), .flow_ctl(flow_ctl), .pin_mode(pin_mode),
        .te_pol(te_pol), .man_rts(man_rts), .man_dtr(man_dtr), .cts_n(cts_n),
        .dsr_n(dsr_n), .tx_busy(tx_busy), .rts_n(rts_n), .dtr_n(dtr_n),
        .tx_permit(tx_permit), .xcvr_en(xcvr_en)
    );

    task automatic check(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // reference model state: throttle flag and delayed busy
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold   <= 0;
            m_busy_d <= 0;
        end else begin
            if (!m_hold && rx_level >= stop_thresh)      m_hold <= 1;
            else if (m_hold && rx_level < resume_thresh) m_hold <= 0;
            m_busy_d <= tx_busy;
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit auto_m, dtr_m, rts_m, clr;
            auto_m = (flow_ctl[2:0] == 3'b001);
            dtr_m  = auto_m && (pin_mode == 3'b010);
            rts_m  = auto_m && !dtr_m;
            clr    = rts_m ? !cts_n : (dtr_m ? !dsr_n : 1'b1);
            check(pin_req, "rts_n", rts_n, rts_m ? m_hold : !man_rts);
            check(pin_req, "dtr_n", dtr_n, dtr_m ? m_hold : !man_dtr);
            check((tx_busy || m_busy_d) ? "R6" : "R5", "tx_permit", tx_permit,
                  clr && !tx_busy && !m_busy_d);
            check(flow_ctl[3] ? (te_pol ? "R9" : "R8") : "R10", "xcvr_en", xcvr_en,
                  (flow_ctl[3] && (tx_busy || m_busy_d)) ? te_pol : !te_pol);
        end
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic ramp();
        for (int i = 0; i <= 15; i++) begin rx_level = 9'(i); tick(1); end
        for (int i = 15; i >= 0; i--) begin rx_level = 9'(i); tick(1); end
    endtask

    task automatic send_char(int len);
        tx_busy = 1; tick(len);
        tx_busy = 0; tick(3);
    endtask

    initial begin
        tick(3);
        // R1: reset state
        check("R1", "rts_n", rts_n, 1);
        check("R1", "dtr_n", dtr_n, 1);
        check("R1", "tx_permit", tx_permit, 1);
        check("R1", "xcvr_en", xcvr_en, 1);
        rst_n = 1; tick(2);

        // R2 manual: pins from bits, clear lines ignored
        pin_req = "R2";
        man_rts = 1; tick(2); man_dtr = 1; tick(2);
        cts_n = 1; dsr_n = 1; tick(2); man_rts = 0; tick(2);
        send_char(4);
        ramp();

        // R3 / R4 automatic request/clear
        pin_req = "R3"; cts_n = 0; man_dtr = 0;
        flow_ctl = 4'b0001; pin_mode = 3'b000; tick(2);
        ramp();
        pin_req = "R4";
        rx_level = 9'd13; tick(3); rx_level = 9'd8; tick(3);
        rx_level = 9'd4; tick(3); rx_level = 9'd3; tick(3);
        rx_level = 9'd11; tick(3); rx_level = 9'd12; tick(3); rx_level = 0; tick(3);

        // R5 / R6 transmit gating
        pin_req = "R3";
        cts_n = 1; tick(3); cts_n = 0; tick(2);
        send_char(5);
        tx_busy = 1; tick(2); cts_n = 1; tick(3); tx_busy = 0; tick(3);
        cts_n = 0; tick(2);
        send_char(1);

        // R11 unused flow codes act as manual
        pin_req = "R11";
        flow_ctl = 4'b0010; man_rts = 1; rx_level = 9'd20; cts_n = 1; tick(3);
        flow_ctl = 4'b0111; man_dtr = 1; tick(3); send_char(2);
        rx_level = 0; man_rts = 0; man_dtr = 0; flow_ctl = 4'b0001; cts_n = 0; tick(3);

        // R7 terminal-ready / set-ready pair
        pin_req = "R7";
        pin_mode = 3'b010; man_rts = 1; dsr_n = 0; cts_n = 1; tick(2);
        ramp();
        dsr_n = 1; tick(2); dsr_n = 0; tick(2);
        send_char(3);
        tx_busy = 1; tick(1); dsr_n = 1; tick(2); tx_busy = 0; tick(3); dsr_n = 0; tick(2);

        // R8 / R9 / R10 half duplex
        pin_req = "R2";
        flow_ctl = 4'b1000; pin_mode = 3'b000; man_rts = 0; te_pol = 0; tick(2);
        send_char(6); send_char(1);
        te_pol = 1; tick(2);
        send_char(4); send_char(1);
        flow_ctl = 4'b0000; tick(2);
        send_char(4);
        te_pol = 0; send_char(2);
        flow_ctl = 4'b1001; cts_n = 0; tick(2);
        send_char(3);
        tick(4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule